// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block decides, for a small 8-bit processor core, which pending interrupt is taken next. It receives the raw request flags of seven sources: two external lines, timers 0, 1 and 2, a serial port whose request is the OR of its receive and transmit flags, and a two-wire serial port. Timer 2 also raises its request from the OR of two flags. Every clock cycle it samples these flags into a pending register, whatever the enables say. The core signals each instruction boundary. At a boundary the block picks the winning enabled request and, on the next edge, pulses a single-cycle take strobe with the 16-bit vector address that the core's forced long call should use.

Software sets up the block through four 8-bit special-function registers on a simple SFR bus. There is a primary enable register with a global enable in bit 7, a secondary enable register for the two-wire source, and two matching priority registers. Each source can be placed in the low or the high priority level. The block keeps one in-service bit per level. These bits let a high-level request preempt a low-level handler, and they stop any request of equal or lower priority from interrupting the current handler. A return-from-interrupt strobe from the core closes the innermost active level.

Top module: `vic2_top`

## Requirements
- R1: After synchronous reset the four registers read 00h, no take strobe is given and both in-service bits are 0. A read is registered: `sfr_rdata` shows, one edge later, the value that the register at `sfr_addr` held before any write on the same edge. Unmapped addresses read 00h.
- R2: Register map: A8h is the primary enable, with bit 7 global, bit 5 timer 2, bit 4 serial, bit 3 timer 1, bit 2 external 1, bit 1 timer 0 and bit 0 external 0. A9h bit 1 enables the two-wire source. B8h and B9h give the priority (1 = high) for the same sources at the same bit positions; B8h bit 7 is unused. Unused bits read 0, and writing them has no effect.
- R3: Request flags are sampled on every edge, independent of the enables. A take happens only on the edge where `insn_boundary` is high, and only for a request that was sampled on the edge before.
- R4: When the global enable bit is 0, no take strobe is ever given, even with requests and source enables set.
- R5: Vectors: external 0 at 0003h, timer 0 at 000Bh, external 1 at 0013h, timer 1 at 001Bh, serial at 0023h, timer 2 at 002Bh, two-wire at 003Bh. `vec_addr` is valid in the cycle that `take_irq` is high.
- R6: An eligible high-level request always wins over any low-level request.
- R7: Within one level, the lowest-numbered source in the order external 0, timer 0, external 1, timer 1, serial, timer 2, two-wire wins.
- R8: While the low level is in service, only high-level requests are taken. While the high level is in service, nothing is taken. A take sets the in-service bit of the level it was taken at.
- R9: A `reti_strobe` clears the high in-service bit if it is set, and otherwise clears the low bit. No take occurs on an edge where `reti_strobe` is high.
- R10: The serial request is the OR of `irq_ser_rx` and `irq_ser_tx`. The timer 2 request is the OR of `irq_tmr2_ovf` and `irq_tmr2_ext`.
- R11: `take_irq` is high for exactly one cycle per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Registered SFR read data |
| irq_ext0 | input | 1 | External line 0 request flag |
| irq_tmr0 | input | 1 | Timer 0 request flag |
| irq_ext1 | input | 1 | External line 1 request flag |
| irq_tmr1 | input | 1 | Timer 1 request flag |
| irq_ser_rx | input | 1 | Serial receive flag |
| irq_ser_tx | input | 1 | Serial transmit flag |
| irq_tmr2_ovf | input | 1 | Timer 2 overflow flag |
| irq_tmr2_ext | input | 1 | Timer 2 external flag |
| irq_tws | input | 1 | Two-wire serial request flag |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| reti_strobe | input | 1 | Core executed a return-from-interrupt |
| take_irq | output | 1 | One-cycle acknowledge strobe |
| vec_addr | output | 16 | Vector address for the forced call |
| in_service | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The assertions check rules that must hold on every cycle. A take is always preceded by a boundary and never follows a return. A cleared global enable or an active high level always yields no take. Every vector ends in 011b. A return with both levels active leaves only the low level set. Which source wins under mixed priorities, the exact vector values, the register read-back masking and the OR merging of the serial and timer 2 flags are shown only by the bench scenarios, which compare every cycle against a behavioural model.

// File: rtl/vic2_pkg.sv
package vic2_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 16;
  localparam int N_SRC  = 7;

  localparam logic [ADDR_W-1:0] A_EN0  = 8'hA8;
  localparam logic [ADDR_W-1:0] A_EN1  = 8'hA9;
  localparam logic [ADDR_W-1:0] A_PRI0 = 8'hB8;
  localparam logic [ADDR_W-1:0] A_PRI1 = 8'hB9;

  localparam logic [DATA_W-1:0] M_EN0  = 8'hBF;
  localparam logic [DATA_W-1:0] M_EN1  = 8'h02;
  localparam logic [DATA_W-1:0] M_PRI0 = 8'h3F;
  localparam logic [DATA_W-1:0] M_PRI1 = 8'h02;

  // Source index 6 (two-wire) skips one slot of the 8-byte vector spacing.
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    int slot;
    slot = (idx == N_SRC - 1) ? N_SRC : idx;
    return VEC_W'(slot * 8 + 3);
  endfunction
endpackage

// File: rtl/vic2_sfr.sv
module vic2_sfr
  import vic2_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int N  = N_SRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [N-1:0]  src_en,
  output logic [N-1:0]  src_hi,
  output logic          gbl_en
);
  logic [DW-1:0] en0_q, en1_q, pri0_q, pri1_q;
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en0_q  <= '0;
      en1_q  <= '0;
      pri0_q <= '0;
      pri1_q <= '0;
    end else if (wr) begin
      case (addr)
        A_EN0:   en0_q  <= wdata & M_EN0;
        A_EN1:   en1_q  <= wdata & M_EN1;
        A_PRI0:  pri0_q <= wdata & M_PRI0;
        A_PRI1:  pri1_q <= wdata & M_PRI1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_EN0:   rd_mux = en0_q;
      A_EN1:   rd_mux = en1_q;
      A_PRI0:  rd_mux = pri0_q;
      A_PRI1:  rd_mux = pri1_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign gbl_en = en0_q[7];
  assign src_en = {en1_q[1], en0_q[N-2:0]};
  assign src_hi = {pri1_q[1], pri0_q[N-2:0]};

  // R2: the unused bit of the primary enable never becomes set
  assert_en0_b6_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !en0_q[6]);
endmodule

// File: rtl/vic2_pick.sv
module vic2_pick
  import vic2_pkg::*;
#(
  parameter int N  = N_SRC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  src_en,
  input  logic [N-1:0]  src_hi,
  input  logic          gbl_en,
  input  logic [1:0]    isv,
  output logic          found,
  output logic [IW-1:0] win_idx,
  output logic          win_hi
);
  logic [N-1:0] live, cand_hi, cand_lo;

  assign live    = pend & src_en & {N{gbl_en}};
  assign cand_hi = live &  src_hi & {N{~isv[1]}};
  assign cand_lo = live & ~src_hi & {N{isv == 2'b00}};

  // Scan from the top so the lowest index is assigned last and wins;
  // the high-level scan runs after the low one and overrides it.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_hi  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_lo[i]) begin
        found   = 1'b1;
        win_idx = IW'(i);
        win_hi  = 1'b0;
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_hi[i]) begin
        found   = 1'b1;
        win_idx = IW'(i);
        win_hi  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vic2_isv.sv
module vic2_isv (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_en,
  input  logic       set_hi,
  input  logic       ret,
  output logic [1:0] isv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      isv <= 2'b00;
    end else if (ret) begin
      if (isv[1]) isv[1] <= 1'b0;
      else        isv[0] <= 1'b0;
    end else if (set_en) begin
      if (set_hi) isv[1] <= 1'b1;
      else        isv[0] <= 1'b1;
    end
  end

  // R9: a return with both levels active closes only the high level
  assert_ret_nest_R9: assert property (@(posedge clk) disable iff (rst)
    (ret && isv == 2'b11) |=> isv == 2'b01);
  // R8: the low level is never entered while the high level is active
  assert_lo_under_hi_R8: assert property (@(posedge clk) disable iff (rst)
    (isv == 2'b10) |=> !$rose(isv[0]));
endmodule

// File: rtl/vic2_top.sv
module vic2_top
  import vic2_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int VW = VEC_W,
  localparam int N  = N_SRC,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sfr_wr,
  input  logic [AW-1:0] sfr_addr,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] sfr_rdata,
  input  logic          irq_ext0,
  input  logic          irq_tmr0,
  input  logic          irq_ext1,
  input  logic          irq_tmr1,
  input  logic          irq_ser_rx,
  input  logic          irq_ser_tx,
  input  logic          irq_tmr2_ovf,
  input  logic          irq_tmr2_ext,
  input  logic          irq_tws,
  input  logic          insn_boundary,
  input  logic          reti_strobe,
  output logic          take_irq,
  output logic [VW-1:0] vec_addr,
  output logic [1:0]    in_service
);
  logic [N-1:0]  src_en, src_hi, pend_q, raw;
  logic          gbl_en, found, win_hi, ack;
  logic [IW-1:0] win_idx;

  assign raw = {irq_tws, irq_tmr2_ovf | irq_tmr2_ext, irq_ser_rx | irq_ser_tx,
                irq_tmr1, irq_ext1, irq_tmr0, irq_ext0};

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= raw;
  end

  vic2_sfr #(.AW(AW), .DW(DW), .N(N)) u_sfr (
    .clk(clk), .rst(rst), .wr(sfr_wr), .addr(sfr_addr), .wdata(sfr_wdata),
    .rdata(sfr_rdata), .src_en(src_en), .src_hi(src_hi), .gbl_en(gbl_en)
  );

  vic2_pick #(.N(N)) u_pick (
    .pend(pend_q), .src_en(src_en), .src_hi(src_hi), .gbl_en(gbl_en),
    .isv(in_service), .found(found), .win_idx(win_idx), .win_hi(win_hi)
  );

  assign ack = insn_boundary & ~reti_strobe & found;

  vic2_isv u_isv (
    .clk(clk), .rst(rst), .set_en(ack), .set_hi(win_hi),
    .ret(reti_strobe), .isv(in_service)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq <= 1'b0;
      vec_addr <= '0;
    end else begin
      take_irq <= ack;
      if (ack) vec_addr <= vec_of(int'(win_idx));
    end
  end

  // R3: a take follows a boundary
  assert_take_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(insn_boundary));
  // R9: no take on a return edge
  assert_no_take_on_ret_R9: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> !$past(reti_strobe));
  // R4: global enable off blocks everything
  assert_gbl_off_R4: assert property (@(posedge clk) disable iff (rst)
    !gbl_en |=> !take_irq);
  // R8: an active high level blocks all takes
  assert_hi_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (in_service[1] && !reti_strobe) |=> !take_irq);
  // R8: each take leaves a level marked in service
  assert_take_marks_R8: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> in_service != 2'b00);
  // R5: every vector sits at offset 3 of an 8-byte slot
  assert_vec_slot_R5: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> vec_addr[2:0] == 3'b011);
endmodule

// File: tb/tb_vic2_top.sv
`timescale 1ns/1ps
module tb_vic2_top;
  logic clk = 0, rst = 1;
  logic sfr_wr = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0;
  logic [7:0] sfr_rdata;
  logic e0 = 0, t0 = 0, e1 = 0, t1 = 0, rx = 0, tx = 0, t2a = 0, t2b = 0, tw = 0;
  logic insn = 0, ret = 0;
  logic take;
  logic [15:0] vec;
  logic [1:0] isv;

  always #4 clk = ~clk;

  vic2_top dut (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .irq_ext0(e0), .irq_tmr0(t0), .irq_ext1(e1), .irq_tmr1(t1),
    .irq_ser_rx(rx), .irq_ser_tx(tx), .irq_tmr2_ovf(t2a), .irq_tmr2_ext(t2b),
    .irq_tws(tw), .insn_boundary(insn), .reti_strobe(ret),
    .take_irq(take), .vec_addr(vec), .in_service(isv)
  );

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference
  int m_ie, m_ie2, m_ip, m_ip2, m_rd, m_vec;
  bit m_take;
  bit [1:0] m_isv;
  bit [6:0] m_pend;

  always @(posedge clk) begin
    int w, wl, en, hi;
    if (rst) begin
      m_ie = 0; m_ie2 = 0; m_ip = 0; m_ip2 = 0; m_rd = 0;
      m_take = 0; m_vec = 0; m_isv = 0; m_pend = 0;
    end else begin
      w = -1; wl = 0;
      for (int l = 1; l >= 0; l--)
        for (int s = 0; s < 7; s++) begin
          en = (s == 6) ? m_ie2[1] : m_ie[s];
          hi = (s == 6) ? m_ip2[1] : m_ip[s];
          if (w < 0 && m_pend[s] && en == 1 && m_ie[7] == 1 && hi == l &&
              ((l == 1) ? (m_isv[1] == 0) : (m_isv == 0))) begin
            w = s; wl = l;
          end
        end
      m_take = insn && !ret && w >= 0;
      if (m_take) m_vec = (w == 6) ? 'h3B : w * 8 + 3;
      case (sfr_addr)
        8'hA8: m_rd = m_ie;
        8'hA9: m_rd = m_ie2;
        8'hB8: m_rd = m_ip;
        8'hB9: m_rd = m_ip2;
        default: m_rd = 0;
      endcase
      if (ret) begin
        if (m_isv[1]) m_isv[1] = 0; else m_isv[0] = 0;
      end else if (m_take) begin
        if (wl == 1) m_isv[1] = 1; else m_isv[0] = 1;
      end
      if (sfr_wr)
        case (sfr_addr)
          8'hA8: m_ie  = sfr_wdata & 8'hBF;
          8'hA9: m_ie2 = sfr_wdata & 8'h02;
          8'hB8: m_ip  = sfr_wdata & 8'h3F;
          8'hB9: m_ip2 = sfr_wdata & 8'h02;
          default: ;
        endcase
      m_pend = {tw, t2a | t2b, rx | tx, t1, e1, t0, e0};
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    cyc++;
    #2;
    if (!rst) begin
      chk(take == m_take, "take", take, m_take);
      chk(isv == m_isv, "in_service", isv, m_isv);
      chk(sfr_rdata == m_rd[7:0], "rdata", sfr_rdata, m_rd);
      if (m_take) chk(vec == m_vec[15:0], "vec", vec, m_vec);
    end
  end

  always @(posedge clk) if (cyc > 20000) begin
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); sfr_addr = a;
    @(negedge clk); chk(sfr_rdata == exp, "explicit read", sfr_rdata, exp);
  endtask
  task automatic bnd;
    @(negedge clk); insn = 1;
    @(negedge clk); insn = 0;
  endtask
  task automatic reti;
    @(negedge clk); ret = 1;
    @(negedge clk); ret = 0;
  endtask
  task automatic expect_take(input logic [15:0] v);
    @(negedge clk); insn = 1;
    @(negedge clk); insn = 0;
    chk(take == 1 && vec == v, "explicit vector", vec, v);
    @(negedge clk);
    chk(take == 0, "strobe width R11", take, 0);
  endtask

  initial begin
    idle(3); rst = 0; idle(2);
    tag = "R1";
    rd(8'hA8, 0); rd(8'hA9, 0); rd(8'hB8, 0); rd(8'hB9, 0); rd(8'h55, 0);
    chk(isv == 0 && take == 0, "reset outputs", isv, 0);

    tag = "R2";
    wr(8'hA8, 8'hFF); rd(8'hA8, 8'hBF);
    wr(8'hA9, 8'hFF); rd(8'hA9, 8'h02);
    wr(8'hB8, 8'hFF); rd(8'hB8, 8'h3F);
    wr(8'hB9, 8'hFD); rd(8'hB9, 8'h00);
    wr(8'hB8, 8'h00);

    tag = "R4";
    wr(8'hA8, 8'h3F);
    @(negedge clk); {e0, t0, e1, t1, rx, t2a, tw} = '1;
    bnd(); bnd(); idle(2);
    chk(isv == 0, "no take with global off", isv, 0);
    @(negedge clk); {e0, t0, e1, t1, rx, t2a, tw} = '0;

    tag = "R10";
    wr(8'hA8, 8'h90);
    @(negedge clk); tx = 1;
    expect_take(16'h0023); reti(); tx = 0; rx = 1;
    expect_take(16'h0023); reti(); rx = 0;
    wr(8'hA8, 8'hA0);
    @(negedge clk); t2b = 1;
    expect_take(16'h002B); reti(); t2b = 0;

    tag = "R3";
    wr(8'hA8, 8'h81);
    @(negedge clk); e0 = 1; insn = 1;
    @(negedge clk); insn = 0; e0 = 0;
    chk(take == 0, "request not sampled yet", take, 0);
    idle(2);
    @(negedge clk); e0 = 1; idle(2); e0 = 0;
    chk(isv == 0, "no boundary no take", isv, 0);

    tag = "R7";
    wr(8'hA8, 8'hBF); wr(8'hA9, 8'h02);
    @(negedge clk); {e0, t0, e1, t1, rx, t2a, tw} = '1;
    expect_take(16'h0003); reti(); e0 = 0;
    expect_take(16'h000B); reti(); t0 = 0;
    expect_take(16'h0013); reti(); e1 = 0;
    expect_take(16'h001B); reti(); t1 = 0;
    expect_take(16'h0023); reti(); rx = 0;
    expect_take(16'h002B); reti(); t2a = 0;
    tag = "R5";
    expect_take(16'h003B); reti();

    tag = "R6";
    wr(8'hB9, 8'h02);
    @(negedge clk); {e0, t0, e1, t1, rx, t2a} = '1;
    expect_take(16'h003B);
    chk(isv == 2'b10, "high level marked", isv, 2);
    tag = "R8";
    bnd(); bnd();
    chk(isv == 2'b10, "high blocks all", isv, 2);
    reti(); wr(8'hB9, 8'h00); wr(8'hB8, 8'h08);
    @(negedge clk); tw = 0;
    expect_take(16'h001B);
    reti();
    wr(8'hB8, 8'h00);
    expect_take(16'h0003);
    bnd(); bnd();
    chk(isv == 2'b01, "low blocks low", isv, 1);
    wr(8'hB8, 8'h20);
    expect_take(16'h002B);
    chk(isv == 2'b11, "nested", isv, 3);

    tag = "R9";
    @(negedge clk); ret = 1; insn = 1;
    @(negedge clk); ret = 0; insn = 0;
    chk(take == 0 && isv == 2'b01, "return closes high first", isv, 1);
    reti();
    chk(isv == 2'b00, "return closes low", isv, 0);
    {e0, t0, e1, t1, rx, t2a} = '0;
    tag = "R11";
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule